// File: doc/BRIEF.md
# Nonvolatile Array Write Controller with Row Programming

This block sits between a CPU data bus and a model of a 384-byte nonvolatile array, organised as six pages of 64 bytes. The CPU picks a page with a bank register and reaches a byte inside it with a 6-bit offset. Array reads behave like ordinary data memory. An array write starts a long programming operation, and a busy timer counts out its duration in clock cycles.

Software has two ways to write. In byte mode, each accepted write programs one location. In row mode, up to eight bytes that share one 8-byte row are gathered in volatile latches at full bus speed. The row is then committed by a set-only start bit in the control register. While programming runs, the control register cannot be written and array accesses are dropped. An enable bit and a standby bit gate every array write.

All CPU reads return their data on `cpu_rdata` one cycle after the request.

Top module: `nvm_row_writer`

## Requirements
- R1: After reset, the control register reads 00h, the bank register reads 0 and no programming is in progress.
- R2: Control register bits, by position: bit0 enable, bit1 busy (read-only), bit2 row mode, bit3 row start (set-only), bit6 standby. When not busy, a read returns enable, row mode and start at their positions. Bit6 always reads 0, and bits 7, 5 and 4 always read 0.
- R3: An accepted array write or row start raises busy in the next cycle. Busy then stays high for exactly PROG_CYCLES cycles.
- R4: In byte mode with enable set, a write to offset o of page p programs flat location p*64+o. Once busy has cleared, a read of that location returns the written byte.
- R5: With enable clear, an array write leaves the array unchanged and does not set busy.
- R6: In row mode, array writes fill the row latch at bit positions A2..A0 of the flat address. They do not change the array and do not set busy. The first write fixes the row (flat address bits 8..3), and later writes to any other row are ignored.
- R7: Writing the control register with enable, row mode and start set programs only the latched bytes of the row. The other bytes of the row stay unchanged. Row mode and start read 0 after programming ends.
- R8: Clearing row mode before start discards the latched bytes. The array stays unchanged and nothing is programmed later from them.
- R9: While busy, control register writes are ignored, and a control register read returns 02h.
- R10: While busy, array writes are dropped and array reads return 00h. The write in progress still completes.
- R11: With standby set, array writes have no effect and do not set busy, and array reads return 00h.
- R12: The bank register (target 2) accepts the values 0 to 5 and ignores larger values. It reads back in bits 2..0. Target 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_tgt | input | 2 | Target: 0 array window, 1 control register, 2 bank register, 3 none |
| cpu_addr | input | 6 | Byte offset inside the selected page |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid one cycle after the request |

## Verification
The bench builds the block with PROG_CYCLES set to 20 and otherwise default geometry. At that setting every one of the 384 locations can be written in byte mode, with the busy duration timed after each write, and then read back against an arithmetic pattern. The short timer also leaves room for cycle-exact accesses placed inside a busy window. The bench then covers row collection with a partly filled row, a write that strays into another row, discarding a row, the enable and standby gating, and the bank range limit.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // control register bit positions
  localparam int CtlEn   = 0;
  localparam int CtlBusy = 1;
  localparam int CtlRow  = 2;
  localparam int CtlGo   = 3;
  localparam int CtlSby  = 6;

  // bus targets
  localparam logic [1:0] TgtArray = 2'd0;
  localparam logic [1:0] TgtCtl   = 2'd1;
  localparam logic [1:0] TgtBank  = 2'd2;

  typedef enum logic [1:0] {JOB_NONE, JOB_BYTE, JOB_ROW} job_e;
  typedef enum logic [1:0] {SEL_ZERO, SEL_ARR, SEL_CTL, SEL_BANK} rsel_e;
endpackage

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int PROG_CYCLES = 625000,
  localparam int CntW = $clog2(PROG_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [CntW-1:0] elapsed
);
  logic [CntW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      left_q <= CntW'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end

  assign done    = busy && (left_q == '0);
  assign elapsed = CntW'(PROG_CYCLES - 1) - left_q;
endmodule

// File: rtl/nvm_row_latch.sv
module nvm_row_latch #(
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 8,
  parameter int ADDR_W    = 9,
  localparam int IdxW = $clog2(ROW_BYTES),
  localparam int TagW = ADDR_W - IdxW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 clear,
  input  logic [IdxW-1:0]      rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic [ROW_BYTES-1:0] mask,
  output logic [TagW-1:0]      tag
);
  logic [DATA_W-1:0] slot_q [ROW_BYTES];
  logic              accept;
  logic [IdxW-1:0]   idx;

  assign idx    = addr[IdxW-1:0];
  assign accept = wr && ((mask == '0) || (addr[ADDR_W-1:IdxW] == tag));

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && idx == IdxW'(g)) slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mask <= '0;
      tag  <= '0;
    end else if (accept) begin
      mask[idx] <= 1'b1;
      if (mask == '0) tag <= addr[ADDR_W-1:IdxW];
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 384,
  localparam int AddrW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AddrW-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AddrW-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/nvm_row_writer.sv
module nvm_row_writer
  import nvm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int PAGES       = 6,
  parameter int ROW_BYTES   = 8,
  parameter int PROG_CYCLES = 625000,
  localparam int OfsW  = $clog2(PAGE_BYTES),
  localparam int PageW = $clog2(PAGES),
  localparam int Depth = PAGES * PAGE_BYTES,
  localparam int AddrW = $clog2(Depth),
  localparam int IdxW  = $clog2(ROW_BYTES),
  localparam int TagW  = AddrW - IdxW,
  localparam int CntW  = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_tgt,
  input  logic [OfsW-1:0]   cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic en_q, row_q, go_q, sby_q;
  logic [PageW-1:0] bank_q;
  job_e  job_q;
  rsel_e rsel_q;
  logic [DATA_W-1:0] ctl_snap_q, bank_snap_q, ctl_view;
  logic [AddrW-1:0]  flat_addr, pend_addr_q, mem_waddr;
  logic [DATA_W-1:0] pend_data_q, mem_wdata, mem_rdata, row_data;
  logic [ROW_BYTES-1:0] row_mask;
  logic [TagW-1:0]   row_tag;
  logic [CntW-1:0]   elapsed;
  logic busy, done, mem_we, mem_re;
  logic acc_arr, acc_ctl, acc_bank;
  logic arr_wr_ok, byte_go, row_wr, ctl_wr, go_req, row_clear, row_end;

  assign flat_addr = AddrW'(bank_q) * AddrW'(PAGE_BYTES) + AddrW'(cpu_addr);

  assign acc_arr  = cpu_req && (cpu_tgt == TgtArray);
  assign acc_ctl  = cpu_req && (cpu_tgt == TgtCtl);
  assign acc_bank = cpu_req && (cpu_tgt == TgtBank);

  assign arr_wr_ok = acc_arr && cpu_we && !busy && en_q && !sby_q;
  assign byte_go   = arr_wr_ok && !row_q;
  assign row_wr    = arr_wr_ok && row_q;
  assign ctl_wr    = acc_ctl && cpu_we && !busy;
  assign go_req    = ctl_wr && cpu_wdata[CtlGo] && cpu_wdata[CtlRow] &&
                     cpu_wdata[CtlEn] && !cpu_wdata[CtlSby];
  assign row_end   = done && (job_q == JOB_ROW);
  assign row_clear = (ctl_wr && !cpu_wdata[CtlRow]) || row_end;

  nvm_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(byte_go || go_req),
    .busy(busy), .done(done), .elapsed(elapsed)
  );

  nvm_row_latch #(.DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES), .ADDR_W(AddrW)) u_latch (
    .clk(clk), .rst(rst), .wr(row_wr), .addr(flat_addr), .wdata(cpu_wdata),
    .clear(row_clear), .rd_idx(elapsed[IdxW-1:0]), .rd_data(row_data),
    .mask(row_mask), .tag(row_tag)
  );

  // control and bank registers, job tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      row_q  <= 1'b0;
      go_q   <= 1'b0;
      sby_q  <= 1'b0;
      bank_q <= '0;
      job_q  <= JOB_NONE;
    end else begin
      if (ctl_wr) begin
        en_q  <= cpu_wdata[CtlEn];
        row_q <= cpu_wdata[CtlRow];
        sby_q <= cpu_wdata[CtlSby];
        go_q  <= go_req;
      end else if (row_end) begin
        row_q <= 1'b0;
        go_q  <= 1'b0;
      end
      if (acc_bank && cpu_we && cpu_wdata < DATA_W'(PAGES))
        bank_q <= cpu_wdata[PageW-1:0];
      if (done) job_q <= JOB_NONE;
      else if (byte_go) job_q <= JOB_BYTE;
      else if (go_req) job_q <= JOB_ROW;
    end
  end

  always_ff @(posedge clk) begin
    if (byte_go) begin
      pend_addr_q <= flat_addr;
      pend_data_q <= cpu_wdata;
    end
  end

  // commit: byte job in the first busy cycle, row job one slot per cycle
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = pend_addr_q;
    mem_wdata = pend_data_q;
    if (busy && job_q == JOB_BYTE) begin
      mem_we = (elapsed == '0);
    end else if (busy && job_q == JOB_ROW) begin
      mem_waddr = {row_tag, elapsed[IdxW-1:0]};
      mem_wdata = row_data;
      mem_we    = (elapsed < CntW'(ROW_BYTES)) && row_mask[elapsed[IdxW-1:0]];
    end
  end

  assign mem_re = acc_arr && !cpu_we && !busy && !sby_q;

  nvm_array #(.DATA_W(DATA_W), .DEPTH(Depth)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(flat_addr), .rdata(mem_rdata)
  );

  // read path
  always_comb begin
    ctl_view = '0;
    if (busy) begin
      ctl_view[CtlBusy] = 1'b1;
    end else begin
      ctl_view[CtlEn]  = en_q;
      ctl_view[CtlRow] = row_q;
      ctl_view[CtlGo]  = go_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q      <= SEL_ZERO;
      ctl_snap_q  <= '0;
      bank_snap_q <= '0;
    end else begin
      ctl_snap_q  <= ctl_view;
      bank_snap_q <= DATA_W'(bank_q);
      if (mem_re) rsel_q <= SEL_ARR;
      else if (acc_ctl && !cpu_we) rsel_q <= SEL_CTL;
      else if (acc_bank && !cpu_we) rsel_q <= SEL_BANK;
      else rsel_q <= SEL_ZERO;
    end
  end

  always_comb begin
    case (rsel_q)
      SEL_ARR:  cpu_rdata = mem_rdata;
      SEL_CTL:  cpu_rdata = ctl_snap_q;
      SEL_BANK: cpu_rdata = bank_snap_q;
      default:  cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nvm_row_writer_chk.sv
module nvm_row_writer_chk #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [1:0]        cpu_tgt,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              busy,
  input logic              en_q,
  input logic              sby_q,
  input logic              mem_we
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_q <= '0;
    else run_q <= run_q + 1;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(busy)) |-> run_q == 32'(PROG_CYCLES));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && cpu_tgt == 2'd1) |=> (cpu_rdata[7:4] == 4'h0));

  p_commit_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_disabled_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cpu_tgt == 2'd0 && !en_q && !busy) |=> !busy);

  p_ctl_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_req && cpu_we && cpu_tgt == 2'd1) |=> ($stable(en_q) && $stable(sby_q)));

  p_busy_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_req && !cpu_we && cpu_tgt == 2'd0) |=> (cpu_rdata == '0));

  p_standby_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (sby_q && cpu_req && !cpu_we && cpu_tgt == 2'd0) |=> (cpu_rdata == '0));
endmodule

bind nvm_row_writer nvm_row_writer_chk #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (.*);

// File: tb/test_nvm_row_writer.sv
module test_nvm_row_writer;
  localparam int P = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0] cpu_tgt = 2'd0;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [7:0] rd;
  logic [7:0] exp_mem [384];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nvm_row_writer #(.PROG_CYCLES(P)) i_nvm_row_writer (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tgt(cpu_tgt),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle; rd holds the response afterwards
  task automatic op(input logic [1:0] t, input logic w, input logic [5:0] a, input logic [7:0] d);
    cpu_req = 1'b1; cpu_we = w; cpu_tgt = t; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    rd = cpu_rdata;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  // poll the control register until busy clears; returns busy read count
  task automatic wait_idle(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      op(2'd1, 1'b0, 6'd0, 8'd0);
      if (!rd[1]) break;
      n++;
    end
  endtask

  task automatic rd_arr(input int page, input int ofs, input string req);
    op(2'd2, 1'b1, 6'd0, 8'(page));
    op(2'd0, 1'b0, 6'(ofs), 8'd0);
    chk(rd == exp_mem[page * 64 + ofs], req, rd, exp_mem[page * 64 + ofs]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h00, "R1 ctl", rd, 8'h00);
    op(2'd2, 1'b0, 0, 0); chk(rd == 8'h00, "R1 bank", rd, 8'h00);
    // R2 layout: FF sets en,row,standby; start blocked by standby; 7,6,5,4 read 0
    op(2'd1, 1'b1, 0, 8'hFF);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h05, "R2 layout", rd, 8'h05);
    op(2'd1, 1'b1, 0, 8'h00);
    // R12 bank range, target 3
    op(2'd2, 1'b1, 0, 8'd5); op(2'd2, 1'b0, 0, 0); chk(rd == 8'd5, "R12 bank 5", rd, 5);
    op(2'd2, 1'b1, 0, 8'd6); op(2'd2, 1'b0, 0, 0); chk(rd == 8'd5, "R12 bank 6 ignored", rd, 5);
    op(2'd3, 1'b0, 0, 0); chk(rd == 8'h00, "R12 target 3", rd, 0);

    // R3 R4 full byte-mode sweep
    op(2'd1, 1'b1, 0, 8'h01);
    for (int a = 0; a < 384; a++) begin
      exp_mem[a] = pat(a);
      op(2'd2, 1'b1, 0, 8'(a / 64));
      op(2'd0, 1'b1, 6'(a % 64), pat(a));
      wait_idle(n);
      chk(n == P, "R3 busy length", n, P);
    end
    for (int a = 0; a < 384; a++) rd_arr(a / 64, a % 64, "R4 readback");

    // R6 R7 row collection and commit, bank 2 row at offsets 24..31
    op(2'd2, 1'b1, 0, 8'd2);
    op(2'd1, 1'b1, 0, 8'h05);
    for (int i = 0; i < 8; i++)
      if (i inside {0, 1, 3, 5, 7}) op(2'd0, 1'b1, 6'(24 + i), 8'(8'hA0 + i));
    op(2'd0, 1'b1, 6'd32, 8'h55);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h05, "R6 no busy in collection", rd, 8'h05);
    op(2'd0, 1'b0, 6'd24, 0); chk(rd == exp_mem[128 + 24], "R6 array untouched", rd, exp_mem[152]);
    op(2'd1, 1'b1, 0, 8'h0D);
    wait_idle(n); chk(n == P, "R7 row busy length", n, P);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h01, "R7 row and start cleared", rd, 8'h01);
    for (int i = 0; i < 8; i++)
      if (i inside {0, 1, 3, 5, 7}) exp_mem[128 + 24 + i] = 8'(8'hA0 + i);
    for (int i = 0; i < 8; i++) rd_arr(2, 24 + i, "R7 row content");
    rd_arr(2, 32, "R6 other row ignored");

    // R8 discard
    op(2'd1, 1'b1, 0, 8'h05);
    op(2'd0, 1'b1, 6'd40, 8'h77);
    op(2'd1, 1'b1, 0, 8'h01);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h01, "R8 no busy after discard", rd, 8'h01);
    rd_arr(2, 40, "R8 array unchanged");
    op(2'd1, 1'b1, 0, 8'h05);
    op(2'd0, 1'b1, 6'd42, 8'h99);
    op(2'd1, 1'b1, 0, 8'h0D);
    wait_idle(n);
    exp_mem[128 + 42] = 8'h99;
    rd_arr(2, 40, "R8 discarded byte not committed");
    rd_arr(2, 42, "R8 later row committed");

    // R9 R10 accesses while busy
    op(2'd1, 1'b1, 0, 8'h01);
    op(2'd2, 1'b1, 0, 8'd1);
    op(2'd0, 1'b1, 6'd5, 8'h3C);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h02, "R9 busy ctl read", rd, 8'h02);
    op(2'd0, 1'b0, 6'd5, 0); chk(rd == 8'h00, "R10 busy array read", rd, 0);
    op(2'd0, 1'b1, 6'd6, 8'hEE);
    op(2'd1, 1'b1, 0, 8'h40);
    wait_idle(n);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h01, "R9 ctl write ignored", rd, 8'h01);
    exp_mem[64 + 5] = 8'h3C;
    rd_arr(1, 5, "R10 in-progress write completes");
    rd_arr(1, 6, "R10 aborted write");

    // R5 disabled
    op(2'd1, 1'b1, 0, 8'h00);
    op(2'd0, 1'b1, 6'd7, 8'h11);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h00, "R5 no busy", rd, 0);
    op(2'd1, 1'b1, 0, 8'h01);
    rd_arr(1, 7, "R5 array unchanged");

    // R11 standby
    op(2'd1, 1'b1, 0, 8'h41);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h01, "R11 standby reads 0", rd, 8'h01);
    op(2'd0, 1'b1, 6'd8, 8'h22);
    op(2'd1, 1'b0, 0, 0); chk(rd == 8'h01, "R11 no busy", rd, 8'h01);
    op(2'd0, 1'b0, 6'd8, 0); chk(rd == 8'h00, "R11 read zero", rd, 0);
    op(2'd1, 1'b1, 0, 8'h01);
    rd_arr(1, 8, "R11 array unchanged");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule